// File: doc/BRIEF.md
# Break Request Source Combiner

This block gathers the fault signals that can stop a PWM timer and merges them into one active-high break request for the timer's protection stage. Four sources feed it: a dedicated break pin, two analog-comparator outputs and a break flag from a digital filter unit. Software sets up the combination through a small 32-bit option register. That register holds one enable per gated source and one polarity per pin-like source. The timer's lock level input can freeze the option register.

Each source is first conditioned, so a high result means "fault present". The break pin always contributes, and only its polarity can be chosen. Each comparator contributes only when it is enabled, and its polarity can be chosen. The filter flag is always active high and contributes only when it is enabled. The conditioned sources are ORed into `brk_req` with no register in the path. A registered copy, `brk_req_q`, follows one cycle later. The timer's global break polarity is then applied to produce `brk_line`. Once the lock level is non-zero, register writes are dropped, so the running configuration cannot be disturbed.

Top module: `brk_src_merge`

## Requirements
- R1: After reset every option bit is 0. `rd_data` reads 0, and `brk_req_q` is 0.
- R2: A write with lock level 0 stores the writable bits, and `rd_data` returns them from the next cycle on. The writable bits are: comparator 1 enable (bit 1), comparator 2 enable (bit 2), filter enable (bit 8), pin polarity (bit 9), comparator 1 polarity (bit 10) and comparator 2 polarity (bit 11). Every other bit, including reserved bits 7:3, reads 0, so writing all ones reads back 0x00000F06.
- R3: While `lock_lvl` is non-zero (1, 2 or 3), a write changes neither `rd_data` nor the break outputs.
- R4: A comparator contributes to the break request only while its enable bit is 1.
- R5: The filter flag contributes, active high, while bit 8 is 1, and never while bit 8 is 0.
- R6: The break pin always contributes. With bit 9 at 0 a low pin is a fault; with bit 9 at 1 a high pin is a fault.
- R7: A comparator polarity bit at 0 makes a low output a fault; at 1 it makes a high output a fault.
- R8: `brk_req` is the combinational OR of all conditioned, enabled sources, valid in the same cycle as the inputs.
- R9: `brk_req_q` equals the value `brk_req` had in the previous cycle.
- R10: `brk_line` equals `brk_req` when `glob_pol` is 1 and its inverse when `glob_pol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Option register write strobe |
| wr_data | input | 32 | Option register write value |
| rd_data | output | 32 | Option register readback |
| lock_lvl | input | 2 | Timer lock level, 0 = unlocked |
| glob_pol | input | 1 | Timer's global break polarity, 1 = active high |
| brk_pin | input | 1 | External break pin |
| cmp_out | input | 2 | Comparator outputs, bit 0 = comparator 1 |
| filt_brk | input | 1 | Digital filter break flag |
| brk_req | output | 1 | Merged break request, combinational |
| brk_req_q | output | 1 | Merged break request, one cycle later |
| brk_line | output | 1 | Break request with global polarity applied |

## Verification
The bench builds the block with its default parameters: a 32-bit register and a 2-bit lock level. This brings every lock encoding (1, 2 and 3) into reach alongside the unlocked state. It also covers the full register width, so the zero readback of the reserved bits 7:3 and of the upper bits can be observed. A table walks each source alone under both polarities, together with its enable on and off. Directed tests then cover all-ones writes, writes under each lock level, and the global polarity inversion.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_W        = 32;
  localparam int LOCK_W       = 2;
  localparam int NUM_CMP      = 2;
  localparam int NUM_SRC      = NUM_CMP + 2;
  localparam int BIT_CMP_EN0  = 1;
  localparam int BIT_FILT_EN  = 8;
  localparam int BIT_PIN_POL  = 9;
  localparam int BIT_CMP_POL0 = 10;

  typedef struct packed {
    logic [NUM_CMP-1:0] cmp_pol;
    logic               pin_pol;
    logic               filt_en;
    logic [NUM_CMP-1:0] cmp_en;
  } opt_t;

  // Mask of bits that hold state; everything else reads zero.
  function automatic logic [REG_W-1:0] opt_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      m[BIT_CMP_EN0 + i]  = 1'b1;
      m[BIT_CMP_POL0 + i] = 1'b1;
    end
    m[BIT_FILT_EN] = 1'b1;
    m[BIT_PIN_POL] = 1'b1;
    return m;
  endfunction

  function automatic opt_t unpack_opt(input logic [REG_W-1:0] r);
    opt_t o;
    for (int i = 0; i < NUM_CMP; i++) begin
      o.cmp_en[i]  = r[BIT_CMP_EN0 + i];
      o.cmp_pol[i] = r[BIT_CMP_POL0 + i];
    end
    o.filt_en = r[BIT_FILT_EN];
    o.pin_pol = r[BIT_PIN_POL];
    return o;
  endfunction

  function automatic logic [REG_W-1:0] pack_opt(input opt_t o);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      r[BIT_CMP_EN0 + i]  = o.cmp_en[i];
      r[BIT_CMP_POL0 + i] = o.cmp_pol[i];
    end
    r[BIT_FILT_EN] = o.filt_en;
    r[BIT_PIN_POL] = o.pin_pol;
    return r;
  endfunction

  // Turn a raw source level into an active-high fault indication.
  function automatic logic cond_src(input logic raw, input logic pol);
    return pol ? raw : ~raw;
  endfunction
endpackage

// File: rtl/brk_opt_reg.sv
module brk_opt_reg
  import brk_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int LW = LOCK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  input  logic [LW-1:0] lock_lvl,
  output opt_t          opt,
  output logic [RW-1:0] rd_data,
  output logic          wr_accept
);
  logic unlocked;
  opt_t opt_q;

  assign unlocked  = (lock_lvl == '0);
  assign wr_accept = wr_en & unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q <= '0;
    end else if (wr_accept) begin
      opt_q <= unpack_opt(wr_data);
    end
  end

  assign opt     = opt_q;
  assign rd_data = pack_opt(opt_q);
endmodule

// File: rtl/brk_src_cond.sv
module brk_src_cond
  import brk_pkg::*;
#(
  parameter int NC = NUM_CMP,
  parameter int NS = NC + 2
) (
  input  opt_t          opt,
  input  logic          brk_pin,
  input  logic [NC-1:0] cmp_out,
  input  logic          filt_brk,
  output logic [NS-1:0] src_hit
);
  // Slot 0: break pin, slots 1..NC: comparators, slot NS-1: filter flag.
  assign src_hit[0] = cond_src(brk_pin, opt.pin_pol);

  for (genvar g = 0; g < NC; g++) begin : g_cmp
    logic lvl;
    assign lvl            = cond_src(cmp_out[g], opt.cmp_pol[g]);
    assign src_hit[1 + g] = lvl & opt.cmp_en[g];
  end

  assign src_hit[NS-1] = filt_brk & opt.filt_en;
endmodule

// File: rtl/brk_or_merge.sv
module brk_or_merge #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_hit,
  input  logic          glob_pol,
  output logic          brk_req,
  output logic          brk_req_q,
  output logic          brk_line
);
  assign brk_req  = |src_hit;
  assign brk_line = glob_pol ? brk_req : ~brk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_req_q <= 1'b0;
    else        brk_req_q <= brk_req;
  end
endmodule

// File: rtl/brk_src_merge.sv
module brk_src_merge
  import brk_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int LW = LOCK_W,
  parameter int NC = NUM_CMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] rd_data,
  input  logic [LW-1:0] lock_lvl,
  input  logic          glob_pol,
  input  logic          brk_pin,
  input  logic [NC-1:0] cmp_out,
  input  logic          filt_brk,
  output logic          brk_req,
  output logic          brk_req_q,
  output logic          brk_line
);
  localparam int NS = NC + 2;

  opt_t          opt;
  logic          wr_accept;
  logic [NS-1:0] src_hit;

  brk_opt_reg #(.RW(RW), .LW(LW)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .lock_lvl (lock_lvl),
    .opt      (opt),
    .rd_data  (rd_data),
    .wr_accept(wr_accept)
  );

  brk_src_cond #(.NC(NC), .NS(NS)) u_cond (
    .opt     (opt),
    .brk_pin (brk_pin),
    .cmp_out (cmp_out),
    .filt_brk(filt_brk),
    .src_hit (src_hit)
  );

  brk_or_merge #(.NS(NS)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_hit  (src_hit),
    .glob_pol (glob_pol),
    .brk_req  (brk_req),
    .brk_req_q(brk_req_q),
    .brk_line (brk_line)
  );
endmodule

// File: rtl/brk_src_merge_chk.sv
module brk_src_merge_chk #(
  parameter int RW = 32,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [RW-1:0] wr_data,
  input logic [RW-1:0] rd_data,
  input logic [LW-1:0] lock_lvl,
  input logic          glob_pol,
  input logic          brk_pin,
  input logic          filt_brk,
  input logic          brk_req,
  input logic          brk_req_q,
  input logic          brk_line,
  input logic          wr_accept
);
  localparam logic [RW-1:0] KEEP = RW'(32'h0000_0F06);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~KEEP) == '0);

  p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_lvl == '0) |=> rd_data == ($past(wr_data) & KEEP));

  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl != '0) |=> $stable(rd_data));

  p_lock_no_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl != '0) |-> !wr_accept);

  p_filt_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_brk && rd_data[8]) |-> brk_req);

  p_pin_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pin == rd_data[9]) |-> brk_req);

  p_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> brk_req_q == $past(brk_req));

  p_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_pol && brk_req) |-> brk_line);

  p_line_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_pol && !brk_req) |-> brk_line);
endmodule

bind brk_src_merge brk_src_merge_chk #(.RW(RW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .lock_lvl (lock_lvl),
  .glob_pol (glob_pol),
  .brk_pin  (brk_pin),
  .filt_brk (filt_brk),
  .brk_req  (brk_req),
  .brk_req_q(brk_req_q),
  .brk_line (brk_line),
  .wr_accept(wr_accept)
);

// File: tb/brk_src_merge_tb.sv
`timescale 1ns/1ps
module brk_src_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  lock_lvl = '0;
  logic        glob_pol = 1'b1;
  logic        brk_pin = 1'b1;
  logic [1:0]  cmp_out = '0;
  logic        filt_brk = 1'b0;
  logic        brk_req, brk_req_q, brk_line;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  brk_src_merge u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lock_lvl(lock_lvl), .glob_pol(glob_pol),
    .brk_pin(brk_pin), .cmp_out(cmp_out), .filt_brk(filt_brk),
    .brk_req(brk_req), .brk_req_q(brk_req_q), .brk_line(brk_line)
  );

  // {pc2,pc1,ppin,fen,en2,en1, pin, cmp[1:0], filt, expected brk_req}
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b000000_1_11_1_0, 11'b000000_0_11_1_1, 11'b001000_1_00_0_1,
    11'b001000_0_00_0_0, 11'b000001_1_11_0_0, 11'b000001_1_10_0_1,
    11'b010001_1_01_0_1, 11'b010001_1_10_0_0, 11'b100010_1_10_0_1,
    11'b100010_1_01_0_0, 11'b000100_1_00_1_1, 11'b000100_1_00_0_0,
    11'b000000_1_00_1_0, 11'b110111_1_00_0_0, 11'b110111_1_10_0_1
  };

  function automatic logic [31:0] cfg_word(input logic [5:0] c);
    return {20'd0, c[5], c[4], c[3], c[2], 5'd0, c[1], c[0], 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    chk("R1 brk_req_q after reset", {31'd0, brk_req_q}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after release", rd_data, 32'h0);

    // Table walk: R4 R5 R6 R7 R8 and R9, R10 with glob_pol high.
    for (int i = 0; i < NV; i++) begin
      reg_write(cfg_word(VEC[i][10:5]));
      brk_pin  = VEC[i][4];
      cmp_out  = VEC[i][3:2];
      filt_brk = VEC[i][1];
      #1;
      chk($sformatf("R4 R5 R6 R7 R8 vec %0d brk_req", i), {31'd0, brk_req}, {31'd0, VEC[i][0]});
      chk($sformatf("R10 vec %0d brk_line", i), {31'd0, brk_line}, {31'd0, VEC[i][0]});
      @(posedge clk);
      #1;
      chk($sformatf("R9 vec %0d brk_req_q", i), {31'd0, brk_req_q}, {31'd0, VEC[i][0]});
    end

    // R2: readback of writable bits only.
    reg_write(32'hFFFF_FFFF);
    chk("R2 all-ones readback", rd_data, 32'h0000_0F06);
    reg_write(32'h0000_00F8);
    chk("R2 reserved 7:3 read zero", rd_data, 32'h0);
    reg_write(32'h0000_0A02);
    chk("R2 partial pattern", rd_data, 32'h0000_0A02);

    // R3: locked writes ignored at every non-zero level.
    reg_write(32'h0000_0F06);
    brk_pin = 1'b1; cmp_out = 2'b00; filt_brk = 1'b0;
    for (int l = 1; l < 4; l++) begin
      lock_lvl = 2'(l);
      reg_write(32'h0);
      #1;
      chk($sformatf("R3 lock %0d rd_data", l), rd_data, 32'h0000_0F06);
      chk($sformatf("R3 lock %0d brk_req", l), {31'd0, brk_req}, 32'h1);
    end
    lock_lvl = 2'd0;
    reg_write(32'h0);
    #1;
    chk("R3 unlocked write lands", rd_data, 32'h0);
    chk("R6 pin high inactive at pol 0", {31'd0, brk_req}, 32'h0);

    // R10: inverted line with global polarity low.
    glob_pol = 1'b0;
    #1;
    chk("R10 idle line when glob_pol=0", {31'd0, brk_line}, 32'h1);
    brk_pin = 1'b0;
    #1;
    chk("R10 break line when glob_pol=0", {31'd0, brk_line}, 32'h0);

    // R9: pipeline lags by one cycle.
    @(negedge clk);
    brk_pin = 1'b1;
    #1;
    chk("R9 q still previous", {31'd0, brk_req_q}, 32'h1);
    @(posedge clk);
    #1;
    chk("R9 q follows", {31'd0, brk_req_q}, 32'h0);

    report();
    $finish;
  end
endmodule